// File: doc/BRIEF.md
# Boot Self-Test Reset Sequencer

This block holds a device in reset after a destructive or an external reset request and runs the boot-time self-test before it lets the application start. The memory test engine runs first. It covers every RAM and the ROM. The three scan-based logic test partitions follow, one after another. Each engine gets a single-cycle start strobe. The sequencer then waits for that engine's done flag and reads its pass flag before it moves on. While this runs, the reset seen outside the device and the internal application reset both stay asserted, so the rest of the system sees an ordinary reset.

Only a clean pass from all four phases releases the two resets. The external one is released first and the application reset follows one cycle later. A phase that reports a failure, or that never reports done within the configured number of cycles, latches the device in reset. A sticky fail flag and a 3-bit phase code show the cause. Only a new reset request clears that latch. A request that arrives at any point, including mid-sequence, abandons the current phase and starts the whole sequence again from the memory phase. The block's own power-on reset `rst_ni` counts as a destructive reset, so the sequence also runs after power-up.

Top module: `bist_reset_seq`

## Requirements
- R1: When `rst_ni` is released, or on the first clock edge at which both request inputs are low after either of them was high, the sequencer starts the memory phase. The memory start strobe (`eng_start_o` bit 0) is high in the cycle after that edge. A request aborts whatever phase is running.
- R2: The phases run in a fixed order, one engine per bit of `eng_start_o`: bit 0 is the memory engine, and bits 1, 2 and 3 are logic partitions 0, 1 and 2. Each strobe lasts one cycle. The next strobe is high in the cycle after the edge at which the current engine's done was sampled high with pass high.
- R3: `sys_rst_o` and `app_rst_o` are 1 (asserted) from reset until every phase has passed. `sys_rst_o` drops in the cycle after the last phase's passing done is sampled, and `app_rst_o` drops one cycle later.
- R4: If a done is sampled with pass low, the sequencer enters a hold state. Both resets stay asserted, no further strobe is issued, `fail_o` becomes 1, and `fail_code_o` shows the failing phase: 1 for memory, 2, 3 and 4 for logic partitions 0, 1 and 2. The code is 0 when there is no failure.
- R5: A phase fails with its own code if its done is not high in any of the `TIMEOUT_CYC` cycles that begin with its start-strobe cycle. A done in the last of those cycles is still accepted.
- R6: Done and pass from engines other than the active one are ignored.
- R7: `fail_o` and `fail_code_o` are sticky. Only a new request or `rst_ni` clears them.
- R8: After release both resets stay deasserted until a request. A request re-asserts both resets in the cycle after its first sampled edge.
- R9: While a request input is held high, no start strobe is issued and `fail_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset, treated as destructive |
| destr_rst_i | input | 1 | Destructive reset request, level |
| ext_rst_i | input | 1 | External reset request, level |
| eng_start_o | output | 4 | One-cycle start strobes: bit 0 memory, bits 1..3 logic partitions 0..2 |
| eng_done_i | input | 4 | Done flags from the engines, same bit order |
| eng_pass_i | input | 4 | Pass flags, valid with the matching done |
| sys_rst_o | output | 1 | Externally visible reset, active high |
| app_rst_o | output | 1 | Application reset, active high |
| fail_o | output | 1 | Sticky self-test failure flag |
| fail_code_o | output | 3 | Failing phase code (0 none, 1 memory, 2..4 logic partition 0..2) |

## Verification
Most wrong internal states show at the ports within one cycle. A wrong sequencer state either strobes the wrong engine, repeats a strobe, or skips one. That shows on `eng_start_o` in the cycle after the offending edge. It also shifts every later strobe, so a cycle-by-cycle comparison against a behavioural model catches it at once. A wrong phase timer shows only when the timeout fires. Latencies of exactly `TIMEOUT_CYC-1` and `TIMEOUT_CYC` are therefore driven, so that an off-by-one shows as a wrong `fail_o` one cycle early or late. A lost sticky bit or a spurious reset release shows on `fail_o` and `sys_rst_o` during the long hold windows after each outcome.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  localparam int unsigned NUM_LBIST = 3;
  localparam int unsigned NUM_ENG   = NUM_LBIST + 1;
  localparam int unsigned IDX_W     = $clog2(NUM_ENG);
  localparam int unsigned CODE_W    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEM,
    ST_LBIST0,
    ST_LBIST1,
    ST_LBIST2,
    ST_PASS,
    ST_FAIL_HOLD
  } seq_state_e;

  function automatic logic is_test(seq_state_e s);
    return (s == ST_MEM) || (s == ST_LBIST0) || (s == ST_LBIST1) || (s == ST_LBIST2);
  endfunction

  function automatic logic [IDX_W-1:0] phase_idx(seq_state_e s);
    case (s)
      ST_LBIST0: return IDX_W'(1);
      ST_LBIST1: return IDX_W'(2);
      ST_LBIST2: return IDX_W'(3);
      default:   return '0;
    endcase
  endfunction

  function automatic seq_state_e next_phase(seq_state_e s);
    case (s)
      ST_MEM:    return ST_LBIST0;
      ST_LBIST0: return ST_LBIST1;
      ST_LBIST1: return ST_LBIST2;
      default:   return ST_PASS;
    endcase
  endfunction
endpackage

// File: rtl/bist_phase_timer.sv
module bist_phase_timer #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bist_resp_sel.sv
module bist_resp_sel import bist_seq_pkg::*; (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_ENG-1:0] done_i,
  input  logic [NUM_ENG-1:0] pass_i,
  output logic               done_o,
  output logic               pass_o
);
  logic [NUM_ENG-1:0] hit_done, hit_pass;

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_sel
    assign hit_done[g] = (idx_i == IDX_W'(g)) && done_i[g];
    assign hit_pass[g] = (idx_i == IDX_W'(g)) && pass_i[g];
  end

  assign done_o = |hit_done;
  assign pass_o = |hit_pass;
endmodule

// File: rtl/bist_rst_out.sv
module bist_rst_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic release_i,
  output logic sys_rst_o,
  output logic app_rst_o
);
  logic sys_q, app_q;

  // app release trails sys release by one cycle; re-assertion is simultaneous
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= 1'b1;
      app_q <= 1'b1;
    end else begin
      sys_q <= !release_i;
      app_q <= sys_q || !release_i;
    end
  end

  assign sys_rst_o = sys_q;
  assign app_rst_o = app_q;
endmodule

// File: rtl/bist_reset_seq.sv
module bist_reset_seq import bist_seq_pkg::*; #(
  parameter int unsigned TIMEOUT_CYC = 4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               destr_rst_i,
  input  logic               ext_rst_i,
  output logic [NUM_ENG-1:0] eng_start_o,
  input  logic [NUM_ENG-1:0] eng_done_i,
  input  logic [NUM_ENG-1:0] eng_pass_i,
  output logic               sys_rst_o,
  output logic               app_rst_o,
  output logic               fail_o,
  output logic [CODE_W-1:0]  fail_code_o
);
  seq_state_e         state_q, state_d;
  logic               pend_q, pend_d;
  logic               fail_q, fail_d;
  logic [CODE_W-1:0]  code_q, code_d;
  logic [NUM_ENG-1:0] start_q, start_d;
  logic               req, in_test, cur_done, cur_pass, expired;
  logic [IDX_W-1:0]   idx;

  assign req     = destr_rst_i || ext_rst_i;
  assign in_test = is_test(state_q);
  assign idx     = phase_idx(state_q);

  bist_resp_sel u_sel (
    .idx_i  (idx),
    .done_i (eng_done_i),
    .pass_i (eng_pass_i),
    .done_o (cur_done),
    .pass_o (cur_pass)
  );

  bist_phase_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (req || (start_d != '0)),
    .run_i     (in_test),
    .expired_o (expired)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    fail_d  = fail_q;
    code_d  = code_q;
    start_d = '0;
    if (req) begin
      state_d = ST_IDLE;
      pend_d  = 1'b1;
      fail_d  = 1'b0;
      code_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pend_q) begin
            state_d = ST_MEM;
            pend_d  = 1'b0;
            start_d = NUM_ENG'(1);
          end
        end
        ST_MEM, ST_LBIST0, ST_LBIST1, ST_LBIST2: begin
          if (cur_done && cur_pass) begin
            state_d = next_phase(state_q);
            if (state_d != ST_PASS) start_d = NUM_ENG'(1) << (idx + 1'b1);
          end else if (cur_done || expired) begin
            state_d = ST_FAIL_HOLD;
            fail_d  = 1'b1;
            code_d  = CODE_W'(idx) + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b1;
      fail_q  <= 1'b0;
      code_q  <= '0;
      start_q <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      fail_q  <= fail_d;
      code_q  <= code_d;
      start_q <= start_d;
    end
  end

  bist_rst_out u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .release_i (state_d == ST_PASS),
    .sys_rst_o (sys_rst_o),
    .app_rst_o (app_rst_o)
  );

  assign eng_start_o = start_q;
  assign fail_o      = fail_q;
  assign fail_code_o = code_q;
endmodule

// File: rtl/bist_seq_chk.sv
module bist_seq_chk import bist_seq_pkg::*; (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               destr_rst_i,
  input logic               ext_rst_i,
  input logic [NUM_ENG-1:0] eng_start_o,
  input logic               sys_rst_o,
  input logic               app_rst_o,
  input logic               fail_o,
  input logic [CODE_W-1:0]  fail_code_o
);
  p_start_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eng_start_o));

  p_start_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o != '0) |=> ((eng_start_o & $past(eng_start_o)) == '0));

  p_app_after_sys_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !app_rst_o |-> !sys_rst_o);

  p_fail_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (sys_rst_o && app_rst_o && eng_start_o == '0));

  p_fail_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fail_code_o >= 3'd1 && fail_code_o <= 3'd4));

  p_fail_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !destr_rst_i && !ext_rst_i) |=> (fail_o && $stable(fail_code_o)));

  p_req_resets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (destr_rst_i || ext_rst_i) |=> (sys_rst_o && app_rst_o));

  p_req_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (destr_rst_i || ext_rst_i) |=> (eng_start_o == '0 && !fail_o));
endmodule

bind bist_reset_seq bist_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .destr_rst_i (destr_rst_i),
  .ext_rst_i   (ext_rst_i),
  .eng_start_o (eng_start_o),
  .sys_rst_o   (sys_rst_o),
  .app_rst_o   (app_rst_o),
  .fail_o      (fail_o),
  .fail_code_o (fail_code_o)
);

// File: tb/tb_bist_reset_seq.sv
module tb_bist_reset_seq;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       destr = 1'b0, ext = 1'b0;
  logic [3:0] start;
  logic [3:0] done = '0, pass = '0;
  logic       sys_rst, app_rst, fail;
  logic [2:0] code;

  always #2 clk = ~clk;

  bist_reset_seq #(.TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .destr_rst_i(destr), .ext_rst_i(ext),
    .eng_start_o(start), .eng_done_i(done), .eng_pass_i(pass),
    .sys_rst_o(sys_rst), .app_rst_o(app_rst), .fail_o(fail), .fail_code_o(code)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // engine stubs
  int lat[4];
  bit pcfg[4];
  bit hang[4];
  int cnt[4];
  bit stray = 0;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      done[i] = 1'b0;
      if (start[i] && !hang[i]) begin
        if (lat[i] == 0) begin done[i] = 1'b1; pass[i] = pcfg[i]; end
        else cnt[i] = lat[i];
      end else if (cnt[i] > 0) begin
        cnt[i]--;
        if (cnt[i] == 0) begin done[i] = 1'b1; pass[i] = pcfg[i]; end
      end
      if (stray && i > 0) begin done[i] = 1'b1; pass[i] = 1'b0; end
    end
  end

  // behavioural reference: 0 idle, 1..4 phases, 5 released, 6 failed
  int m_st, m_t, ns;
  bit m_pend, m_sys, m_app, m_fail;
  int m_code;
  bit [3:0] m_start, nst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 1; m_t = 0; m_start = 0;
      m_sys = 1; m_app = 1; m_fail = 0; m_code = 0;
    end else begin
      ns = m_st; nst = 0;
      if (destr || ext) begin
        ns = 0; m_pend = 1; m_fail = 0; m_code = 0;
      end else if (m_st == 0) begin
        if (m_pend) begin ns = 1; nst = 4'b0001; m_pend = 0; m_t = 0; end
      end else if (m_st >= 1 && m_st <= 4) begin
        if (done[m_st-1] && pass[m_st-1]) begin
          ns = m_st + 1;
          if (ns <= 4) nst = 4'(1 << (ns - 1));
          m_t = 0;
        end else if (done[m_st-1] || m_t == TO - 1) begin
          ns = 6; m_fail = 1; m_code = m_st;
        end else m_t++;
      end
      m_app = m_sys || (ns != 5);
      m_sys = (ns != 5);
      m_start = nst;
      m_st = ns;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(start == m_start, "R2 start strobes", start, m_start);
      chk(sys_rst == m_sys, "R3 sys_rst", sys_rst, m_sys);
      chk(app_rst == m_app, "R3 app_rst", app_rst, m_app);
      chk(fail == m_fail, "R4 fail flag", fail, m_fail);
      chk(code == 3'(m_code), "R4 fail code", code, m_code);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int l0, int l1, int l2, int l3, bit [3:0] p, bit [3:0] h);
    lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
    for (int i = 0; i < 4; i++) begin pcfg[i] = p[i]; hang[i] = h[i]; cnt[i] = 0; end
  endtask

  task automatic request(bit use_ext, int hold);
    @(negedge clk);
    if (use_ext) ext = 1'b1; else destr = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(sys_rst && app_rst, "R8 resets on request", {sys_rst, app_rst}, 3);
      chk(start == 4'b0 && !fail, "R9 quiet during request", start, 0);
    end
    ext = 1'b0; destr = 1'b0;
    for (int i = 0; i < 4; i++) cnt[i] = 0;
  endtask

  initial begin
    cfg(3, 5, 1, 7, 4'b1111, 4'b0000);
    cyc(4);
    chk(sys_rst && app_rst, "R3 reset state resets", {sys_rst, app_rst}, 3);
    chk(start == 0 && !fail && code == 0, "R1 reset state idle", start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start == 4'b0001, "R1 memory strobe after reset", start, 1);
    cyc(80);
    chk(!sys_rst && !app_rst && !fail, "R3 released after all pass", {sys_rst, app_rst}, 0);
    cyc(30);
    chk(!sys_rst && !app_rst, "R8 stays released", {sys_rst, app_rst}, 0);

    // memory phase fails
    cfg(2, 2, 2, 2, 4'b1110, 4'b0000);
    request(1, 2);
    cyc(40);
    chk(fail && code == 1, "R4 memory fail code", code, 1);
    cyc(60);
    chk(fail && code == 1 && sys_rst && app_rst, "R7 fail sticky", code, 1);

    // stray done from inactive engines
    cfg(10, 2, 2, 2, 4'b1111, 4'b0000);
    request(0, 1);
    stray = 1; cyc(6); stray = 0;
    cyc(60);
    chk(!fail && !sys_rst && !app_rst, "R6 stray done ignored", fail, 0);

    // logic partition 1 fails
    cfg(1, 0, 4, 1, 4'b1011, 4'b0000);
    request(1, 1);
    cyc(40);
    chk(fail && code == 3, "R4 partition 1 fail code", code, 3);

    // abort in the middle of partition 0
    cfg(1, 30, 1, 1, 4'b1111, 4'b0000);
    request(0, 1);
    cyc(15);
    chk(sys_rst && !fail, "R1 mid-sequence", sys_rst, 1);
    cfg(1, 2, 1, 1, 4'b1111, 4'b0000);
    request(0, 3);
    @(negedge clk);
    chk(start == 4'b0001, "R1 restart from memory", start, 1);
    cyc(40);
    chk(!sys_rst && !fail, "R1 restarted sequence passes", sys_rst, 0);

    // partition 2 hangs
    cfg(1, 1, 1, 0, 4'b1111, 4'b1000);
    request(1, 1);
    cyc(60);
    chk(fail && code == 4, "R5 timeout partition 2", code, 4);

    // timeout boundary on memory phase
    cfg(TO - 1, 1, 1, 1, 4'b1111, 4'b0000);
    request(0, 1);
    cyc(70);
    chk(!fail && !sys_rst, "R5 done in last window cycle accepted", fail, 0);
    cfg(TO, 1, 1, 1, 4'b1111, 4'b0000);
    request(0, 1);
    cyc(70);
    chk(fail && code == 1, "R5 done one cycle late fails", code, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule